// File: doc/BRIEF.md
# Single-Level Page Table Address Translator

This block turns a logical address into a physical address by looking it up in a small page table held on chip. The low `PAGE_BITS` bits of the logical address are the byte offset within a page, and they pass through unchanged. The remaining upper bits are the page number. The page number selects one table entry, which holds a frame number and a present bit. The physical address is the frame number placed above the offset, which equals frame × page size + offset. The page size is always a power of two, 2^`PAGE_BITS`. A deployed configuration uses pages from 512 bytes up to 16 MB, and the parameter also accepts smaller pages for tests.

Software or a controller loads the table through a plain write port: page index, frame number and present bit. A write takes effect at the next clock edge. Lookups arrive on a valid/ready request stream and leave on a valid/ready response stream, in order, one response per accepted request. A request is accepted on any edge where `req_valid` and `req_ready` are both high. Its result is captured at that edge into a response queue of `RSP_DEPTH` entries. The head of the queue stays on the response port, with a stable payload, until `rsp_ready` is high. `req_ready` drops only while the queue is full, so it never depends on `rsp_ready` within the same cycle. If a looked-up entry is not present, the response has its fault flag set and its address forced to zero.

Top module: `page_xlate`

## Requirements
- R1: The low `PAGE_BITS` bits of `req_laddr` form the page offset and appear unchanged as the low `PAGE_BITS` bits of `rsp_paddr`. The upper `LADDR_W-PAGE_BITS` bits form the page number that selects the table entry.
- R2: For a present entry, `rsp_paddr` = {frame, offset}, that is frame × 2^`PAGE_BITS` + offset, and `rsp_fault` = 0.
- R3: For an entry that is not present, `rsp_fault` = 1 and `rsp_paddr` = 0.
- R4: Reset marks every table entry as not present and empties the response queue: `rsp_valid` = 0 and `req_ready` = 1 after reset.
- R5: When `tbl_we` = 1 at an edge, entry `tbl_page` takes `tbl_frame` and present bit `tbl_present`. Requests accepted at later edges see the new contents, and overwriting an entry replaces its old mapping.
- R6: When a request is accepted at the same edge as a table write to the page it looks up, its response uses the table contents from before the write.
- R7: Each accepted request yields exactly one response, in acceptance order. If the queue is empty, the response is visible on the port in the cycle after acceptance.
- R8: While `rsp_valid` = 1 and `rsp_ready` = 0, the response is held with an unchanged payload. `req_ready` = 0 exactly when `RSP_DEPTH` responses are pending.
- R9: With 4-byte pages, and the mapping page 0 → frame 5, page 1 → frame 6, page 3 → frame 2, logical addresses 0, 3, 4 and 13 translate to 20, 23, 24 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_page | input | LADDR_W-PAGE_BITS | Page index to write |
| tbl_frame | input | PADDR_W-PAGE_BITS | Frame number to store |
| tbl_present | input | 1 | Present bit to store |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_laddr | input | LADDR_W | Logical address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_paddr | output | PADDR_W | Physical address (zero on fault) |
| rsp_fault | output | 1 | Page fault: entry not present |

## Verification
The assertions assume that the consumer, after a reset, never takes a response that was not offered. They also assume that requests are counted only when `req_valid` and `req_ready` are both high, so the checker's outstanding count can be derived from port handshakes alone. The stimulus holds each request and its address stable until it is accepted. It toggles `rsp_ready` only in a separate driver that is sampled on the same handshake rule, so the pending count tracked at the ports stays consistent with the design's queue.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  typedef enum logic [0:0] {
    XL_HIT   = 1'b0,
    XL_FAULT = 1'b1
  } xl_status_e;

  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/ptt_table.sv
module ptt_table #(
  parameter int unsigned PAGES   = 128,
  parameter int unsigned FRAME_W = 11,
  localparam int unsigned IDX_W  = $clog2(PAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_present,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [FRAME_W-1:0] rd_frame,
  output logic               rd_present
);
  logic [FRAME_W-1:0] frame_q   [PAGES];
  logic [PAGES-1:0]   present_q;

  for (genvar e = 0; e < PAGES; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        present_q[e] <= 1'b0;
      end else if (hit) begin
        present_q[e] <= wr_present;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        frame_q[e] <= wr_frame;
      end
    end
  end

  // Read is combinational from the registers: a write at the same edge
  // lands after this value is captured downstream, so lookups see old data.
  assign rd_frame   = frame_q[rd_idx];
  assign rd_present = present_q[rd_idx];
endmodule

// File: rtl/ptt_compose.sv
module ptt_compose
  import ptt_pkg::*;
#(
  parameter int unsigned LADDR_W   = 16,
  parameter int unsigned PAGE_BITS = 9,
  parameter int unsigned PADDR_W   = 20,
  localparam int unsigned VPN_W    = LADDR_W - PAGE_BITS,
  localparam int unsigned FRAME_W  = PADDR_W - PAGE_BITS
) (
  input  logic [LADDR_W-1:0] laddr,
  output logic [VPN_W-1:0]   page_idx,
  input  logic [FRAME_W-1:0] frame,
  input  logic               present,
  output logic [PADDR_W-1:0] paddr,
  output xl_status_e         status
);
  logic [PAGE_BITS-1:0] offset;

  assign page_idx = laddr[LADDR_W-1:PAGE_BITS];
  assign offset   = laddr[PAGE_BITS-1:0];

  always_comb begin
    if (present) begin
      status = XL_HIT;
      paddr  = {frame, offset};
    end else begin
      status = XL_FAULT;
      paddr  = '0;
    end
  end
endmodule

// File: rtl/ptt_rsp_fifo.sv
module ptt_rsp_fifo
  import ptt_pkg::*;
#(
  parameter int unsigned WIDTH = 21,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PTR_W = ptr_w(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             full,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import ptt_pkg::*;
#(
  parameter int unsigned LADDR_W   = 16,
  parameter int unsigned PAGE_BITS = 9,
  parameter int unsigned PADDR_W   = 20,
  parameter int unsigned RSP_DEPTH = 2,
  localparam int unsigned VPN_W    = LADDR_W - PAGE_BITS,
  localparam int unsigned FRAME_W  = PADDR_W - PAGE_BITS,
  localparam int unsigned PAGES    = 1 << VPN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [VPN_W-1:0]   tbl_page,
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic               tbl_present,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LADDR_W-1:0] req_laddr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic               rsp_fault
);
  logic [VPN_W-1:0]   look_idx;
  logic [FRAME_W-1:0] look_frame;
  logic               look_present;
  logic [PADDR_W-1:0] look_paddr;
  xl_status_e         look_status;
  logic               q_full;
  logic               accept;
  logic [PADDR_W:0]   q_out;

  ptt_table #(.PAGES(PAGES), .FRAME_W(FRAME_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_idx    (tbl_page),
    .wr_frame  (tbl_frame),
    .wr_present(tbl_present),
    .rd_idx    (look_idx),
    .rd_frame  (look_frame),
    .rd_present(look_present)
  );

  ptt_compose #(.LADDR_W(LADDR_W), .PAGE_BITS(PAGE_BITS), .PADDR_W(PADDR_W)) u_compose (
    .laddr   (req_laddr),
    .page_idx(look_idx),
    .frame   (look_frame),
    .present (look_present),
    .paddr   (look_paddr),
    .status  (look_status)
  );

  assign req_ready = !q_full;
  assign accept    = req_valid && req_ready;

  ptt_rsp_fifo #(.WIDTH(PADDR_W + 1), .DEPTH(RSP_DEPTH)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_data({look_status == XL_FAULT, look_paddr}),
    .full     (q_full),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (q_out)
  );

  assign rsp_fault = q_out[PADDR_W];
  assign rsp_paddr = q_out[PADDR_W-1:0];
endmodule

// File: rtl/page_xlate_checker.sv
module page_xlate_checker #(
  parameter int unsigned PADDR_W   = 20,
  parameter int unsigned RSP_DEPTH = 2,
  localparam int unsigned OUT_W    = $clog2(RSP_DEPTH + 1) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PADDR_W-1:0] rsp_paddr,
  input logic               rsp_fault
);
  logic [OUT_W-1:0] outst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst <= '0;
    end else begin
      outst <= outst + OUT_W'(req_valid && req_ready) - OUT_W'(rsp_valid && rsp_ready);
    end
  end

  p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outst >= OUT_W'(RSP_DEPTH)) |-> !req_ready);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (outst != '0));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outst == '0 && req_valid && req_ready) |=> rsp_valid);

  p_empty_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outst == '0) |-> (req_ready && !rsp_valid));
endmodule

bind page_xlate page_xlate_checker #(.PADDR_W(PADDR_W), .RSP_DEPTH(RSP_DEPTH)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault)
);

// File: tb/page_xlate_tb.sv
`timescale 1ns/1ps
module page_xlate_tb;
  localparam int LW = 6, PB = 2, PW = 6, DEPTH = 2;
  localparam int VW = LW - PB, FW = PW - PB, NP = 1 << VW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [VW-1:0] tbl_page = '0;
  logic [FW-1:0] tbl_frame = '0;
  logic tbl_present = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LW-1:0] req_laddr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [PW-1:0] rsp_paddr;
  logic rsp_fault;

  always #2.5 clk = ~clk;

  page_xlate #(.LADDR_W(LW), .PAGE_BITS(PB), .PADDR_W(PW), .RSP_DEPTH(DEPTH)) u_dut (.*);

  typedef struct { logic [PW-1:0] pa; logic f; string tag; } exp_t;
  exp_t q[$];
  logic [FW-1:0] m_frame [NP];
  bit m_vld [NP];
  int compared = 0, mismatched = 0;
  string cur_tag = "R7";
  bit bp_mode = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model, evaluated between edges for the coming edge
  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < NP; i++) m_vld[i] = 1'b0;
    end else begin
      chk(req_ready == (q.size() < DEPTH), "R8", "req_ready", req_ready, q.size() < DEPTH);
      chk(rsp_valid == (q.size() > 0), "R7", "rsp_valid", rsp_valid, q.size() > 0);
      if (rsp_valid && q.size() > 0) begin
        chk(rsp_paddr == q[0].pa, q[0].tag, "rsp_paddr", rsp_paddr, q[0].pa);
        chk(rsp_fault == q[0].f, q[0].tag, "rsp_fault", rsp_fault, q[0].f);
        if (rsp_ready) void'(q.pop_front());
      end
      if (req_valid && req_ready) begin
        exp_t e;
        int pg;
        pg = int'(req_laddr[LW-1:PB]);
        e.f = !m_vld[pg];
        e.pa = m_vld[pg] ? {m_frame[pg], req_laddr[PB-1:0]} : '0;
        e.tag = cur_tag;
        q.push_back(e);
      end
      if (tbl_we) begin
        m_frame[tbl_page] = tbl_frame;
        m_vld[tbl_page] = tbl_present;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    rsp_ready = bp_mode ? 1'($urandom % 2) : 1'b1;
  end

  task automatic wr(input int pg, input int fr, input bit pr);
    @(posedge clk); #1;
    tbl_we = 1'b1; tbl_page = VW'(pg); tbl_frame = FW'(fr); tbl_present = pr;
    @(posedge clk); #1;
    tbl_we = 1'b0;
  endtask

  task automatic send(input int la, input string tag);
    bit acc;
    @(posedge clk); #1;
    cur_tag = tag; req_valid = 1'b1; req_laddr = LW'(la);
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((q.size() > 0 || rsp_valid) && n < 1000) begin @(posedge clk); n++; end
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R4: queue empty after reset
    chk(rsp_valid == 1'b0, "R4", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R4", "req_ready after reset", req_ready, 1);
    // R4: every entry faults after reset
    for (int p = 0; p < NP; p += 5) send(p << PB, "R4");
    drain();

    // R9: worked example with 4-byte pages
    wr(0, 5, 1); wr(1, 6, 1); wr(2, 1, 1); wr(3, 2, 1);
    send(0, "R9"); send(3, "R9"); send(4, "R9"); send(13, "R9");
    drain();

    // R1/R2: every offset of a page passes through
    wr(7, 11, 1);
    for (int o = 0; o < (1 << PB); o++) send((7 << PB) | o, "R1");
    send((2 << PB) | 2, "R2");
    drain();

    // R3: absent entry faults with zero address
    wr(9, 15, 0);
    send((9 << PB) | 3, "R3");
    send((12 << PB) | 1, "R3");
    // R5: overwrite an entry, then make it absent
    wr(7, 3, 1);
    send((7 << PB) | 1, "R5");
    wr(7, 3, 0);
    send((7 << PB) | 1, "R5");
    drain();

    // R6: write and lookup of the same page at the same edge
    wr(4, 8, 1);
    @(posedge clk); #1;
    tbl_we = 1'b1; tbl_page = 4'd4; tbl_frame = 4'd13; tbl_present = 1'b1;
    cur_tag = "R6"; req_valid = 1'b1; req_laddr = LW'((4 << PB) | 2);
    @(posedge clk); #1;
    tbl_we = 1'b0; req_valid = 1'b0;
    send((4 << PB) | 2, "R6");
    @(posedge clk); #1;
    tbl_we = 1'b1; tbl_page = 4'd5; tbl_present = 1'b0;
    cur_tag = "R6"; req_valid = 1'b1; req_laddr = LW'(5 << PB);
    @(posedge clk); #1;
    tbl_we = 1'b0; req_valid = 1'b0;
    drain();

    // R7/R8: random traffic under back-pressure with table updates
    bp_mode = 1'b1;
    for (int i = 0; i < 600; i++) begin
      bit acc;
      @(negedge clk); acc = req_valid && req_ready;
      @(posedge clk); #1;
      tbl_we = 1'($urandom % 4 == 0);
      tbl_page = VW'($urandom); tbl_frame = FW'($urandom); tbl_present = 1'($urandom % 3 != 0);
      if (!req_valid || acc) begin
        cur_tag = "R8";
        req_valid = 1'($urandom % 4 != 0);
        req_laddr = LW'($urandom);
      end
    end
    @(posedge clk); #1;
    tbl_we = 1'b0;
    while (req_valid) begin
      bit acc;
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
      if (acc) req_valid = 1'b0;
    end
    bp_mode = 1'b0;
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule